// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block drives a 64-word by 16-bit serial EEPROM that has a chip select, a serial clock, a data input and a data output. A host raises a one-cycle request that carries a read/write flag, a 6-bit word address and, for writes, a 16-bit word. The block then runs the whole pin sequence on its own. When it finishes it raises a one-cycle done pulse, presents the read word and flags a write whose completion was never seen.

Each pin level is held for one step. A step is a programmable number of system clocks, about 50 µs on silicon and a handful of clocks in simulation. A read is a single command with a data phase. A write is a bracketed sequence: a write-enable command, a standby toggle of chip select, the program command with its data, a second standby, a busy-poll of the data output with a bounded count, a third standby, a write-disable command and a closing clock pulse. The data output of the memory passes through a two-flop synchroniser before any sample is taken.

Top module: `mw_eeprom_master`

## Requirements
- R1: During and after reset, with no request taken, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `err` are all low.
- R2: A request is taken only when `busy` is low. `busy` rises in the cycle after the request is taken and falls in the cycle `done` is high. A request raised while `busy` is high is ignored: the pin sequence in progress is unchanged and `busy` stays high.
- R3: Every pin level lasts exactly `STEP_CYCLES` clocks. The pins follow the request edge by one clock. A transaction opens with one step of all pins low, then one step with `ee_cs` high.
- R4: Command bits leave MSB first. Each bit takes three steps with `ee_cs` high and `ee_di` holding the bit: clock low, then clock high, then clock low.
- R5: A read sends opcode 110 and the 6-bit address (9 bits). It then clocks in 16 bits, MSB first. Each bit takes one step with the clock high and one step with the clock low, and `ee_di` stays low. `ee_do` is sampled at the end of the clock-high step, and the level must be steady over the last three clocks of that step. `rdata` holds the assembled word at `done`.
- R6: A write runs in this order: opcode 10011 plus four zero bits, standby, opcode 101 with the address and the 16 data bits (25 bits), standby, poll, standby, opcode 10000 plus four zero bits, cleanup.
- R7: A standby is four steps with `ee_di` low. The (`ee_cs`, `ee_sk`) pair goes (0,0), (0,1), (1,1), (1,0).
- R8: Each poll step holds `ee_cs` high and `ee_sk`, `ee_di` low, and samples `ee_do` at its end. A high sample ends the poll. If `POLL_LIMIT` polls all sample low, `err` is set and the sequence still runs to its end.
- R9: Both reads and writes end with a cleanup: one step with every pin low, one with only `ee_sk` high, then one with every pin low. `done` pulses for one cycle right after the last cleanup step.
- R10: `err` is cleared when a new request is taken and is never set by a read. A write leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to program on a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Write completion never seen (valid with done) |
| rdata | output | DATA_W | Last word read |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The hardest path to reach is the write timeout. Reaching it takes a data output that stays low through all 200 poll samples, so that the error flag is raised while the disable command and the cleanup still follow. The bench's memory stand-in is told, per transaction, how many poll steps to hold the data output low. One write sets a count beyond the limit, and the next read confirms the flag clears. Other writes use counts of zero and three, which cover an immediate reply and a late one. A request pulse injected mid-transaction covers the busy-ignore path.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP_LO,
    ST_SETUP_CS,
    ST_RD_CMD,
    ST_RD_IN,
    ST_EN_CMD,
    ST_SB_PRE,
    ST_WR_CMD,
    ST_SB_ARM,
    ST_POLL,
    ST_SB_POST,
    ST_DIS_CMD,
    ST_CLEAN
  } mw_state_e;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } mw_pins_t;

  localparam int OPC_W     = 3;
  localparam int CTL_W     = 5;
  localparam int CTL_PAD_W = 4;

  localparam logic [OPC_W-1:0] OPC_READ  = 3'b110;
  localparam logic [OPC_W-1:0] OPC_WRITE = 3'b101;
  localparam logic [CTL_W-1:0] OPC_WEN   = 5'b10011;
  localparam logic [CTL_W-1:0] OPC_WDIS  = 5'b10000;

endpackage

// File: rtl/mw_step_timer.sv
module mw_step_timer #(
  parameter int STEP_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic step_end
);
  localparam int CNT_W = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign step_end = run && (cnt_q == LAST);

  always_comb begin
    if (!run || step_end) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the step counter never passes the last count of a step
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= 1'b0;
          else        stg_q[i] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= 1'b0;
          else        stg_q[i] <= stg_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (shift_en) word_q <= {word_q[DATA_W-2:0], bit_in};
  end

  assign word = word_q;

endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int POLL_LIMIT = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              step_end,
  input  logic              dout_s,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rx_shift,
  output mw_pins_t          pins
);
  localparam int FRAME_W   = OPC_W + ADDR_W + DATA_W;
  localparam int CTL_FRAME = CTL_W + CTL_PAD_W;
  localparam int RD_FRAME  = OPC_W + ADDR_W;
  localparam int BIT_W     = $clog2(FRAME_W + 1);
  localparam int POLL_W    = $clog2(POLL_LIMIT + 1);

  mw_state_e          state_q, state_d;
  logic [1:0]         sub_q, sub_d;
  logic [BIT_W-1:0]   bits_q, bits_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [POLL_W-1:0]  poll_q, poll_d;
  logic               err_q, err_d;
  logic               done_q, done_d;
  logic               wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  mw_pins_t           pins_q, pins_d;
  logic               accept;

  logic [FRAME_W-1:0] frame_rd, frame_wr, frame_wen, frame_wds;

  assign frame_rd  = {OPC_READ, addr_q, {DATA_W{1'b0}}};
  assign frame_wr  = {OPC_WRITE, addr_q, data_q};
  assign frame_wen = {OPC_WEN, {CTL_PAD_W{1'b0}}, {(FRAME_W-CTL_FRAME){1'b0}}};
  assign frame_wds = {OPC_WDIS, {CTL_PAD_W{1'b0}}, {(FRAME_W-CTL_FRAME){1'b0}}};

  assign accept = (state_q == ST_IDLE) && req;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    sub_d    = sub_q;
    bits_d   = bits_q;
    sh_d     = sh_q;
    poll_d   = poll_q;
    err_d    = err_q;
    done_d   = 1'b0;
    rx_shift = 1'b0;
    if (state_q == ST_IDLE) begin
      if (req) begin
        state_d = ST_SETUP_LO;
        sub_d   = 2'd0;
        err_d   = 1'b0;
      end
    end else if (step_end) begin
      case (state_q)
        ST_SETUP_LO: state_d = ST_SETUP_CS;
        ST_SETUP_CS: begin
          sub_d = 2'd0;
          if (wr_q) begin
            state_d = ST_EN_CMD;
            sh_d    = frame_wen;
            bits_d  = BIT_W'(CTL_FRAME);
          end else begin
            state_d = ST_RD_CMD;
            sh_d    = frame_rd;
            bits_d  = BIT_W'(RD_FRAME);
          end
        end
        ST_RD_CMD, ST_EN_CMD, ST_WR_CMD, ST_DIS_CMD: begin
          if (sub_q == 2'd2) begin
            sub_d  = 2'd0;
            sh_d   = {sh_q[FRAME_W-2:0], 1'b0};
            bits_d = bits_q - 1'b1;
            if (bits_q == BIT_W'(1)) begin
              case (state_q)
                ST_RD_CMD: begin
                  state_d = ST_RD_IN;
                  bits_d  = BIT_W'(DATA_W);
                end
                ST_EN_CMD: state_d = ST_SB_PRE;
                ST_WR_CMD: state_d = ST_SB_ARM;
                default:   state_d = ST_CLEAN;
              endcase
            end
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        ST_RD_IN: begin
          if (sub_q == 2'd0) begin
            rx_shift = 1'b1;
            sub_d    = 2'd1;
          end else begin
            sub_d  = 2'd0;
            bits_d = bits_q - 1'b1;
            if (bits_q == BIT_W'(1)) state_d = ST_CLEAN;
          end
        end
        ST_SB_PRE, ST_SB_ARM, ST_SB_POST: begin
          if (sub_q == 2'd3) begin
            sub_d = 2'd0;
            case (state_q)
              ST_SB_PRE: begin
                state_d = ST_WR_CMD;
                sh_d    = frame_wr;
                bits_d  = BIT_W'(FRAME_W);
              end
              ST_SB_ARM: begin
                state_d = ST_POLL;
                poll_d  = '0;
              end
              default: begin
                state_d = ST_DIS_CMD;
                sh_d    = frame_wds;
                bits_d  = BIT_W'(CTL_FRAME);
              end
            endcase
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        ST_POLL: begin
          if (dout_s) begin
            state_d = ST_SB_POST;
          end else if (poll_q == POLL_W'(POLL_LIMIT - 1)) begin
            err_d   = 1'b1;
            state_d = ST_SB_POST;
          end else begin
            poll_d = poll_q + 1'b1;
          end
        end
        ST_CLEAN: begin
          if (sub_q == 2'd2) begin
            state_d = ST_IDLE;
            sub_d   = 2'd0;
            done_d  = 1'b1;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // pin levels for the step in progress
  always_comb begin
    pins_d = '0;
    case (state_q)
      ST_SETUP_CS: pins_d.cs = 1'b1;
      ST_RD_CMD, ST_EN_CMD, ST_WR_CMD, ST_DIS_CMD: begin
        pins_d.cs = 1'b1;
        pins_d.di = sh_q[FRAME_W-1];
        pins_d.sk = (sub_q == 2'd1);
      end
      ST_RD_IN: begin
        pins_d.cs = 1'b1;
        pins_d.sk = (sub_q == 2'd0);
      end
      ST_SB_PRE, ST_SB_ARM, ST_SB_POST: begin
        pins_d.cs = sub_q[1];
        pins_d.sk = (sub_q == 2'd1) || (sub_q == 2'd2);
      end
      ST_POLL:  pins_d.cs = 1'b1;
      ST_CLEAN: pins_d.sk = (sub_q == 2'd1);
      default:  pins_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      bits_q  <= '0;
      sh_q    <= '0;
      poll_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      pins_q  <= '0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      bits_q  <= bits_d;
      sh_q    <= sh_d;
      poll_q  <= poll_d;
      err_q   <= err_d;
      done_q  <= done_d;
      pins_q  <= pins_d;
    end
  end

  // request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      wr_q   <= req_wr;
      addr_q <= req_addr;
      data_q <= req_wdata;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;
  assign pins = pins_q;

  // R2: a request seen while busy never ends the transaction early
  p_busy_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> (busy || done_q));

  // R8: the poll count stays inside its limit
  p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLL) |-> (poll_q < POLL_W'(POLL_LIMIT)));

  // R9: done lasts exactly one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10: a fresh transaction starts with the error flag clear
  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !err_q);

endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
  import mw_pkg::*;
#(
  parameter int STEP_CYCLES = 5000,
  parameter int POLL_LIMIT  = 200,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int SYNC_STAGES = 2;

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       step_end;
  logic       dout_s;
  logic       rx_shift;
  mw_pins_t   pins;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  mw_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (busy),
    .step_end (step_end)
  );

  mw_sync #(.STAGES(SYNC_STAGES)) u_do_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (ee_do),
    .q     (dout_s)
  );

  mw_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .shift_en (rx_shift),
    .bit_in   (dout_s),
    .word     (rdata)
  );

  mw_seq #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .POLL_LIMIT (POLL_LIMIT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req       (req_valid),
    .req_wr    (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .step_end  (step_end),
    .dout_s    (dout_s),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .rx_shift  (rx_shift),
    .pins      (pins)
  );

  assign ee_cs = pins.cs;
  assign ee_sk = pins.sk;
  assign ee_di = pins.di;

  // R1: with no transaction running the pins rest low
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!busy && $past(!busy)) |-> !(ee_cs || ee_sk || ee_di));

  // R3: pins move only at step boundaries
  p_pin_step_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$stable({ee_cs, ee_sk, ee_di}) |-> $past(step_end, 2));

endmodule

// File: tb/test_mw_eeprom_master.sv
module test_mw_eeprom_master;
  localparam int CLK_PERIOD = 10;
  localparam int STEP       = 6;
  localparam int POLLS      = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        ee_do;
  logic        busy, done, err, ee_cs, ee_sk, ee_di;
  logic [15:0] rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference state
  logic        e_cs, e_sk, e_di, e_busy, e_done, e_err;
  logic [15:0] e_rdata;
  string       cur_tag, rd_tag, err_tag;
  bit          cmp_en = 1'b0;
  logic [15:0] mem_word = '0;
  int          poll_wait = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_master #(.STEP_CYCLES(STEP), .POLL_LIMIT(POLLS)) i_mw_eeprom_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one step of the reference: pins change one clock after the step starts
  task automatic mstep(input logic c, input logic s, input logic d,
                       input logic dov, input string tag);
    @(posedge clk);
    e_cs = c; e_sk = s; e_di = d; cur_tag = tag;
    ee_do <= dov;
    repeat (STEP-1) @(posedge clk);
  endtask

  task automatic shout(input logic [31:0] frame, input int n, input string tag);
    for (int i = n-1; i >= 0; i--) begin
      mstep(1'b1, 1'b0, frame[i], 1'b1, tag);
      mstep(1'b1, 1'b1, frame[i], 1'b1, tag);
      mstep(1'b1, 1'b0, frame[i], 1'b1, tag);
    end
  endtask

  task automatic standby();
    mstep(1'b0, 1'b0, 1'b0, 1'b1, "R7");
    mstep(1'b0, 1'b1, 1'b0, 1'b1, "R7");
    mstep(1'b1, 1'b1, 1'b0, 1'b1, "R7");
    mstep(1'b1, 1'b0, 1'b0, 1'b1, "R7");
  endtask

  task automatic cleanup();
    mstep(1'b0, 1'b0, 1'b0, 1'b1, "R9");
    mstep(1'b0, 1'b1, 1'b0, 1'b1, "R9");
    mstep(1'b0, 1'b0, 1'b0, 1'b1, "R9");
  endtask

  // reference model, stepped on every rising edge
  initial begin : model
    logic        m_wr;
    logic [5:0]  m_a;
    logic [15:0] m_d, m_rom;
    int          m_pw;
    e_cs = 0; e_sk = 0; e_di = 0; e_busy = 0; e_done = 0; e_err = 0;
    e_rdata = '0; cur_tag = "R1"; rd_tag = "R5"; err_tag = "R8";
    ee_do = 1'b0;
    forever begin
      @(posedge clk);
      e_done = 0;
      if (rst_n && req_valid && !e_busy) begin
        e_busy = 1; e_err = 0;
        m_wr = req_write; m_a = req_addr; m_d = req_wdata;
        m_rom = mem_word; m_pw = poll_wait;
        mstep(1'b0, 1'b0, 1'b0, 1'b1, "R3");
        mstep(1'b1, 1'b0, 1'b0, 1'b1, "R3");
        if (!m_wr) begin
          shout({23'd0, 3'b110, m_a}, 9, "R4");
          for (int i = 15; i >= 0; i--) begin
            mstep(1'b1, 1'b1, 1'b0, m_rom[i], "R5");
            mstep(1'b1, 1'b0, 1'b0, 1'b1, "R5");
          end
        end else begin
          shout({23'd0, 5'b10011, 4'b0000}, 9, "R6");
          standby();
          shout({7'd0, 3'b101, m_a, m_d}, 25, "R6");
          standby();
          for (int j = 0; j < POLLS; j++) begin
            automatic logic v = (j >= m_pw);
            mstep(1'b1, 1'b0, 1'b0, v, "R8");
            if (v) break;
            if (j == POLLS-1) e_err = 1;
          end
          standby();
          shout({23'd0, 5'b10000, 4'b0000}, 9, "R6");
        end
        cleanup();
        e_done = 1; e_busy = 0;
        if (!m_wr) begin
          e_rdata = m_rom; rd_tag = "R5"; err_tag = "R10";
        end else begin
          rd_tag = "R10"; err_tag = "R8";
        end
      end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      chk(cur_tag, "ee_cs", ee_cs, e_cs);
      chk(cur_tag, "ee_sk", ee_sk, e_sk);
      chk(cur_tag, "ee_di", ee_di, e_di);
      chk("R2", "busy", busy, e_busy);
      chk("R9", "done", done, e_done);
      if (e_done) begin
        chk(err_tag, "err", err, e_err);
        chk(rd_tag, "rdata", rdata, e_rdata);
      end
    end
  end

  task automatic run_op(input logic wr, input logic [5:0] a, input logic [15:0] d,
                        input logic [15:0] rom, input int pw, input bit poke);
    mem_word = rom; poll_wait = pw;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      // R2: a second request mid-transaction must be ignored
      repeat (3*STEP) @(negedge clk);
      req_valid = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2", "busy after ignored request", busy, 1'b1);
    end
    while (!e_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ee_cs in reset", ee_cs, 1'b0);
    chk("R1", "ee_sk in reset", ee_sk, 1'b0);
    chk("R1", "ee_di in reset", ee_di, 1'b0);
    chk("R1", "busy in reset", busy, 1'b0);
    chk("R1", "done in reset", done, 1'b0);
    chk("R1", "err in reset", err, 1'b0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    repeat (6) @(negedge clk);

    run_op(1'b0, 6'h2A, 16'h0000, 16'hA5C3, 0, 1'b1);   // R5 read with ignored poke (R2)
    run_op(1'b0, 6'h00, 16'h0000, 16'hFFFF, 0, 1'b0);   // R5 lowest address, all ones
    run_op(1'b0, 6'h3F, 16'h0000, 16'h0001, 0, 1'b0);   // R5 highest address
    run_op(1'b1, 6'h05, 16'h1234, 16'h0000, 3, 1'b0);   // R6 late completion
    chk("R10", "rdata kept over write", rdata, 16'h0001);
    chk("R8", "err after completed write", err, 1'b0);
    run_op(1'b1, 6'h3F, 16'hFFFF, 16'h0000, 0, 1'b1);   // R6 immediate completion, poke
    run_op(1'b1, 6'h11, 16'h8001, 16'h0000, 1000, 1'b0); // R8 timeout
    chk("R8", "err after timeout", err, 1'b1);
    run_op(1'b0, 6'h15, 16'h0000, 16'h5A5A, 0, 1'b0);   // R10 err clears
    chk("R10", "err cleared by read", err, 1'b0);
    chk("R1", "ee_cs idle", ee_cs, 1'b0);
    chk("R1", "busy idle", busy, 1'b0);
    repeat (4) @(negedge clk);
    summary();
  end

endmodule